// File: doc/BRIEF.md
# Instruction-Boundary Exception Priority Resolver

This block sits beside the execute stage of a small processor core. Each time the core reaches the point between two instructions it raises a one-cycle `boundary` strobe. With that strobe it presents a set of per-category status flags:

- a trap left by the instruction that just retired;
- external non-maskable and maskable interrupt requests;
- an execution breakpoint on the next instruction;
- faults seen while fetching or decoding the next instruction;
- coprocessor availability conditions for WAIT and ESC opcodes, and the coprocessor error pin;
- a segment fault found while moving the instruction's operand.

The resolver walks a fixed nine-step order and picks the single event to service. One clock after the strobe it emits `vec_valid` with an 8-bit `vec_num`.

The resolver also remembers when it has just started a handler for a segment-class exception (vectors 10 to 13). If another exception arrives before the core reports that invocation finished, it turns the new event into a double fault (vector 8). NMI requests are caught on their rising edge and held until serviced. Once an NMI has been serviced, further NMI edges are locked out until the handler signals its return.

Top module: `exc_boundary_arbiter`

## Requirements
- R1: After reset, `vec_valid` and `intr_ack` are 0, no NMI is pending and no handler invocation is in flight, so a first illegal opcode yields vector 6, not 8.
- R2: `vec_valid` is high for exactly the one clock following a `boundary` cycle in which at least one cause is present; without `boundary` it stays low whatever the cause inputs are.
- R3: Causes are ranked in this order: retired-instruction trap, external interrupt, execution breakpoint, prefetch fault, decode fault, WAIT check, ESC check, error pin, operand-transfer fault. Only the highest-ranked present cause is reported.
- R4: `trap_step` and `exec_bp` both report vector 1.
- R5: A rising edge on `nmi_in` makes an NMI pending, reported as vector 2 ahead of INTR. It stays pending while a higher-ranked trap wins a boundary.
- R6: INTR is reported only when `int_enable` is 1 and no NMI is pending. Its vector is `intr_vec`, sampled at that boundary, and `intr_ack` pulses together with `vec_valid`.
- R7: Once an NMI has been reported, further `nmi_in` edges are ignored until a `handler_ret` pulse arrives.
- R8: A prefetch fault reports 13 when `prefetch_gp` is 1, else 11. A decode fault reports 6 for `illegal_op`, which wins over `too_long` and `priv_viol`; those two report 13.
- R9: With `op_wait`, vector 7 is raised when `cr_ts` and `cr_mp` are both 1. With `op_esc`, vector 7 is raised when `cr_em` or `cr_ts` is 1. `fpu_error` raises 16 only with WAIT or ESC, and only when no vector 7 applies. Without either opcode it is ignored.
- R10: An operand-transfer fault maps `xfer_code` 0 to vector 11, 1 to 12, and 2 or 3 to 13.
- R11: Reporting vector 10 to 13 starts an in-flight invocation. It ends on `invoke_done` or on any other report. While it is in flight, any cause other than an external interrupt at a boundary reports vector 8 instead. External interrupts are not escalated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction boundary strobe |
| trap_step | input | 1 | Single-step or data-breakpoint trap from retired instruction |
| nmi_in | input | 1 | Non-maskable interrupt request (edge) |
| intr_req | input | 1 | Maskable interrupt request (level) |
| int_enable | input | 1 | Maskable interrupt enable flag |
| intr_vec | input | 8 | Vector supplied by interrupt controller |
| exec_bp | input | 1 | Execution breakpoint on next instruction |
| prefetch_flt | input | 1 | Segment fault while fetching next instruction |
| prefetch_gp | input | 1 | Prefetch fault kind: 1 = vector 13, 0 = vector 11 |
| illegal_op | input | 1 | Undefined opcode |
| too_long | input | 1 | Instruction exceeds 15 bytes |
| priv_viol | input | 1 | Privilege violation |
| op_wait | input | 1 | Next opcode is WAIT |
| op_esc | input | 1 | Next opcode is a coprocessor escape |
| cr_ts | input | 1 | Task-switched flag |
| cr_mp | input | 1 | Monitor-coprocessor flag |
| cr_em | input | 1 | Emulate-coprocessor flag |
| fpu_error | input | 1 | Coprocessor error pin |
| xfer_flt | input | 1 | Segment fault on operand transfer |
| xfer_code | input | 2 | Operand fault kind: 0 = 11, 1 = 12, 2/3 = 13 |
| handler_ret | input | 1 | NMI handler return pulse |
| invoke_done | input | 1 | Handler invocation completed pulse |
| vec_valid | output | 1 | One-cycle dispatch strobe |
| vec_num | output | 8 | Dispatched vector number |
| intr_ack | output | 1 | Maskable interrupt acknowledge |

## Verification
The checker watches the following on every cycle:
- that a dispatch strobe only follows a boundary;
- that an acknowledge only comes with a dispatch made while interrupts were enabled;
- that a retired-instruction trap outside an invocation always yields vector 1;
- that any exception during an in-flight segment invocation becomes vector 8;
- that an NMI is never taken while the lockout is active.

The full mapping of causes to vectors needs the bench's directed boundaries, because it depends on which flags are combined. These include the coprocessor flag combinations and the ordering between adjacent steps. The same holds for the NMI pending state surviving a trap, the lockout released by a handler return, and the in-flight window closed by `invoke_done`.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int VEC_W   = 8;
  localparam int N_STEPS = 9;
  localparam int IDX_W   = $clog2(N_STEPS);

  typedef logic [VEC_W-1:0] vec_t;

  // vector numbers
  localparam vec_t VN_DEBUG  = 8'd1;
  localparam vec_t VN_NMI    = 8'd2;
  localparam vec_t VN_INVOP  = 8'd6;
  localparam vec_t VN_NOCOP  = 8'd7;
  localparam vec_t VN_DOUBLE = 8'd8;
  localparam vec_t VN_SEGNP  = 8'd11;
  localparam vec_t VN_STACK  = 8'd12;
  localparam vec_t VN_GPROT  = 8'd13;
  localparam vec_t VN_COPERR = 8'd16;
  localparam vec_t VN_SEG_LO = 8'd10;
  localparam vec_t VN_SEG_HI = 8'd13;

  // check order; a lower index wins
  typedef enum logic [IDX_W-1:0] {
    S_TRAP, S_EXT, S_XBP, S_FETCH, S_DECODE, S_WAIT, S_ESC, S_CERR, S_XFER
  } step_e;
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/exc_nmi_gate.sv
module exc_nmi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  input  logic handler_ret,
  output logic pending,
  output logic blocked
);
  logic level_q, pend_q, block_q;
  logic pend_d, block_d, rise;

  assign rise = nmi_in & ~level_q;

  always_comb begin
    pend_d  = (pend_q & ~take) | (rise & ~block_q & ~take);
    block_d = block_q;
    if (take)             block_d = 1'b1;
    else if (handler_ret) block_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pend_q  <= 1'b0;
      block_q <= 1'b0;
    end else begin
      level_q <= nmi_in;
      pend_q  <= pend_d;
      block_q <= block_d;
    end
  end

  assign pending = pend_q;
  assign blocked = block_q;
endmodule

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_arb_pkg::*;
(
  input  logic       trap_step,
  input  logic       nmi_pend,
  input  logic       intr_req,
  input  logic       int_enable,
  input  vec_t       intr_vec,
  input  logic       exec_bp,
  input  logic       prefetch_flt,
  input  logic       prefetch_gp,
  input  logic       illegal_op,
  input  logic       too_long,
  input  logic       priv_viol,
  input  logic       op_wait,
  input  logic       op_esc,
  input  logic       cr_ts,
  input  logic       cr_mp,
  input  logic       cr_em,
  input  logic       fpu_error,
  input  logic       xfer_flt,
  input  logic [1:0] xfer_code,
  output logic [N_STEPS-1:0] hit,
  output vec_t       vecs [N_STEPS],
  output logic       exc_any,
  output logic       ext_is_nmi
);
  always_comb begin
    hit[S_TRAP]   = trap_step;
    hit[S_EXT]    = nmi_pend | (intr_req & int_enable);
    hit[S_XBP]    = exec_bp;
    hit[S_FETCH]  = prefetch_flt;
    hit[S_DECODE] = illegal_op | too_long | priv_viol;
    hit[S_WAIT]   = op_wait & cr_ts & cr_mp;
    hit[S_ESC]    = op_esc & (cr_em | cr_ts);
    hit[S_CERR]   = (op_wait | op_esc) & fpu_error;
    hit[S_XFER]   = xfer_flt;

    vecs[S_TRAP]   = VN_DEBUG;
    vecs[S_EXT]    = nmi_pend ? VN_NMI : intr_vec;
    vecs[S_XBP]    = VN_DEBUG;
    vecs[S_FETCH]  = prefetch_gp ? VN_GPROT : VN_SEGNP;
    vecs[S_DECODE] = illegal_op ? VN_INVOP : VN_GPROT;
    vecs[S_WAIT]   = VN_NOCOP;
    vecs[S_ESC]    = VN_NOCOP;
    vecs[S_CERR]   = VN_COPERR;
    case (xfer_code)
      2'd0:    vecs[S_XFER] = VN_SEGNP;
      2'd1:    vecs[S_XFER] = VN_STACK;
      default: vecs[S_XFER] = VN_GPROT;
    endcase
  end

  assign exc_any    = |(hit & ~(N_STEPS'(1) << S_EXT));
  assign ext_is_nmi = nmi_pend;
endmodule

// File: rtl/exc_step_select.sv
module exc_step_select
  import exc_arb_pkg::*;
#(
  parameter int N = N_STEPS
) (
  input  logic [N-1:0]     hit,
  input  vec_t             vecs [N],
  output logic             any,
  output vec_t             sel_vec,
  output logic [IDX_W-1:0] sel_idx
);
  always_comb begin
    any     = |hit;
    sel_vec = '0;
    sel_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_vec = vecs[i];
        sel_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/exc_boundary_arbiter.sv
module exc_boundary_arbiter
  import exc_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary,
  input  logic       trap_step,
  input  logic       nmi_in,
  input  logic       intr_req,
  input  logic       int_enable,
  input  logic [7:0] intr_vec,
  input  logic       exec_bp,
  input  logic       prefetch_flt,
  input  logic       prefetch_gp,
  input  logic       illegal_op,
  input  logic       too_long,
  input  logic       priv_viol,
  input  logic       op_wait,
  input  logic       op_esc,
  input  logic       cr_ts,
  input  logic       cr_mp,
  input  logic       cr_em,
  input  logic       fpu_error,
  input  logic       xfer_flt,
  input  logic [1:0] xfer_code,
  input  logic       handler_ret,
  input  logic       invoke_done,
  output logic       vec_valid,
  output logic [7:0] vec_num,
  output logic       intr_ack
);
  logic             rst_core_n;
  logic             nmi_pend, nmi_block, nmi_take;
  logic [N_STEPS-1:0] hit;
  vec_t             vecs [N_STEPS];
  logic             exc_any, ext_is_nmi, any;
  vec_t             sel_vec;
  logic [IDX_W-1:0] sel_idx;
  logic             valid_q, valid_d, ack_q, ack_d, infl_q, infl_d;
  vec_t             vec_q, vec_d;

  exc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n));

  exc_nmi_gate u_nmi (
    .clk(clk), .rst_n(rst_core_n), .nmi_in(nmi_in), .take(nmi_take),
    .handler_ret(handler_ret), .pending(nmi_pend), .blocked(nmi_block)
  );

  exc_cause_decode u_dec (
    .trap_step(trap_step), .nmi_pend(nmi_pend), .intr_req(intr_req),
    .int_enable(int_enable), .intr_vec(intr_vec), .exec_bp(exec_bp),
    .prefetch_flt(prefetch_flt), .prefetch_gp(prefetch_gp),
    .illegal_op(illegal_op), .too_long(too_long), .priv_viol(priv_viol),
    .op_wait(op_wait), .op_esc(op_esc), .cr_ts(cr_ts), .cr_mp(cr_mp),
    .cr_em(cr_em), .fpu_error(fpu_error), .xfer_flt(xfer_flt),
    .xfer_code(xfer_code), .hit(hit), .vecs(vecs), .exc_any(exc_any),
    .ext_is_nmi(ext_is_nmi)
  );

  exc_step_select #(.N(N_STEPS)) u_sel (
    .hit(hit), .vecs(vecs), .any(any), .sel_vec(sel_vec), .sel_idx(sel_idx)
  );

  // next-state: dispatch decision for this boundary
  always_comb begin
    valid_d  = 1'b0;
    vec_d    = '0;
    ack_d    = 1'b0;
    nmi_take = 1'b0;
    infl_d   = infl_q & ~invoke_done;
    if (boundary) begin
      if (infl_q && exc_any) begin
        valid_d = 1'b1;
        vec_d   = VN_DOUBLE;
        infl_d  = 1'b0;
      end else if (any) begin
        valid_d = 1'b1;
        vec_d   = sel_vec;
        infl_d  = (sel_idx != S_EXT) && (sel_vec >= VN_SEG_LO) && (sel_vec <= VN_SEG_HI);
        if (sel_idx == S_EXT) begin
          nmi_take = ext_is_nmi;
          ack_d    = ~ext_is_nmi;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      ack_q   <= 1'b0;
      infl_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      vec_q   <= vec_d;
      ack_q   <= ack_d;
      infl_q  <= infl_d;
    end
  end

  assign vec_valid = valid_q;
  assign vec_num   = vec_q;
  assign intr_ack  = ack_q;
endmodule

// File: rtl/exc_arb_chk.sv
module exc_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boundary,
  input logic       trap_step,
  input logic       int_enable,
  input logic       vec_valid,
  input logic [7:0] vec_num,
  input logic       intr_ack,
  input logic       in_flight,
  input logic       exc_any,
  input logic       nmi_take,
  input logic       nmi_block
);
  // R2
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(boundary));

  // R6
  ack_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |-> (vec_valid && $past(int_enable)));

  // R4
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && trap_step && !in_flight) |=> (vec_valid && vec_num == 8'd1 && !intr_ack));

  // R11
  double_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && in_flight && exc_any) |=> (vec_valid && vec_num == 8'd8));

  // R7
  nmi_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |-> !nmi_block);
endmodule

bind exc_boundary_arbiter exc_arb_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .boundary(boundary), .trap_step(trap_step),
  .int_enable(int_enable), .vec_valid(vec_valid), .vec_num(vec_num),
  .intr_ack(intr_ack), .in_flight(infl_q), .exc_any(exc_any),
  .nmi_take(nmi_take), .nmi_block(nmi_block)
);

// File: tb/test_exc_boundary_arbiter.sv
`timescale 1ns/1ps
module test_exc_boundary_arbiter;
  logic clk = 1'b0;
  logic rst_n;
  logic boundary, trap_step, nmi_in, intr_req, int_enable;
  logic [7:0] intr_vec;
  logic exec_bp, prefetch_flt, prefetch_gp, illegal_op, too_long, priv_viol;
  logic op_wait, op_esc, cr_ts, cr_mp, cr_em, fpu_error, xfer_flt;
  logic [1:0] xfer_code;
  logic handler_ret, invoke_done;
  logic vec_valid, intr_ack;
  logic [7:0] vec_num;

  typedef struct {
    int         due;
    bit         v;
    logic [7:0] vec;
    bit         ack;
    string      tag;
  } item_t;

  item_t sb[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  exc_boundary_arbiter i_exc_boundary_arbiter (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .trap_step(trap_step),
    .nmi_in(nmi_in), .intr_req(intr_req), .int_enable(int_enable),
    .intr_vec(intr_vec), .exec_bp(exec_bp), .prefetch_flt(prefetch_flt),
    .prefetch_gp(prefetch_gp), .illegal_op(illegal_op), .too_long(too_long),
    .priv_viol(priv_viol), .op_wait(op_wait), .op_esc(op_esc), .cr_ts(cr_ts),
    .cr_mp(cr_mp), .cr_em(cr_em), .fpu_error(fpu_error), .xfer_flt(xfer_flt),
    .xfer_code(xfer_code), .handler_ret(handler_ret), .invoke_done(invoke_done),
    .vec_valid(vec_valid), .vec_num(vec_num), .intr_ack(intr_ack)
  );

  task automatic clear_causes();
    trap_step = 0; intr_req = 0; int_enable = 0; intr_vec = 8'h00;
    exec_bp = 0; prefetch_flt = 0; prefetch_gp = 0; illegal_op = 0;
    too_long = 0; priv_viol = 0; op_wait = 0; op_esc = 0; cr_ts = 0;
    cr_mp = 0; cr_em = 0; fpu_error = 0; xfer_flt = 0; xfer_code = 2'd0;
  endtask

  // driver: one boundary with the causes already set, expectation queued
  task automatic at_boundary(input bit ev, input logic [7:0] evec, input bit eack,
                             input string tag);
    item_t it;
    @(negedge clk);
    boundary = 1'b1;
    it.due = cyc + 1; it.v = ev; it.vec = evec; it.ack = eack; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    boundary = 1'b0;
    clear_causes();
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
  endtask

  task automatic pulse_ret();
    @(negedge clk); handler_ret = 1'b1;
    @(negedge clk); handler_ret = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); invoke_done = 1'b1;
    @(negedge clk); invoke_done = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        n_chk++;
        if (vec_valid !== it.v || (it.v && (vec_num !== it.vec || intr_ack !== it.ack))
            || (!it.v && intr_ack !== 1'b0)) begin
          n_fail++;
          $display("FAIL %s: got valid=%0b vec=%0d ack=%0b, expected valid=%0b vec=%0d ack=%0b",
                   it.tag, vec_valid, vec_num, intr_ack, it.v, it.vec, it.ack);
        end
      end else if (vec_valid) begin
        n_chk++; n_fail++;
        $display("FAIL R2 stray dispatch: got valid=1 vec=%0d, expected valid=0", vec_num);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; boundary = 0; nmi_in = 0; handler_ret = 0; invoke_done = 0;
    clear_causes();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    n_chk++;
    if (vec_valid !== 1'b0 || intr_ack !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: got valid=%0b ack=%0b, expected 0 0", vec_valid, intr_ack);
    end
    at_boundary(0, 0, 0, "R1 no NMI pending after reset");
    illegal_op = 1; at_boundary(1, 6, 0, "R1 not in flight after reset");

    // R2 causes without strobe
    trap_step = 1; illegal_op = 1;
    repeat (3) @(negedge clk);
    n_chk++;
    if (vec_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 no strobe: got valid=%0b, expected 0", vec_valid);
    end
    clear_causes();

    // R4 vector 1 sources, R3 ordering
    trap_step = 1; at_boundary(1, 1, 0, "R4 single-step trap");
    exec_bp = 1; at_boundary(1, 1, 0, "R4 execution breakpoint");
    exec_bp = 1; prefetch_flt = 1; at_boundary(1, 1, 0, "R3 breakpoint over prefetch");

    // R5 NMI
    pulse_nmi();
    trap_step = 1; intr_req = 1; int_enable = 1; intr_vec = 8'h40;
    at_boundary(1, 1, 0, "R5 trap beats pending NMI");
    intr_req = 1; int_enable = 1; intr_vec = 8'h40; exec_bp = 1;
    at_boundary(1, 2, 0, "R5 NMI over INTR and breakpoint");
    // R6 INTR
    intr_req = 1; int_enable = 1; intr_vec = 8'h40;
    at_boundary(1, 8'h40, 1, "R6 INTR after NMI");
    intr_req = 1; int_enable = 0; intr_vec = 8'h41;
    at_boundary(0, 0, 0, "R6 INTR masked");

    // R7 lockout
    pulse_nmi();
    at_boundary(0, 0, 0, "R7 NMI edge ignored before return");
    pulse_ret();
    pulse_nmi();
    at_boundary(1, 2, 0, "R7 NMI after handler return");
    pulse_ret();

    // R8 prefetch and decode
    prefetch_flt = 1; illegal_op = 1; at_boundary(1, 11, 0, "R8 prefetch 11 over decode");
    pulse_done();
    prefetch_flt = 1; prefetch_gp = 1; at_boundary(1, 13, 0, "R8 prefetch 13");
    pulse_done();
    illegal_op = 1; too_long = 1; at_boundary(1, 6, 0, "R8 illegal beats length");
    too_long = 1; at_boundary(1, 13, 0, "R8 too long");
    pulse_done();
    priv_viol = 1; at_boundary(1, 13, 0, "R8 privilege");
    pulse_done();

    // R9 coprocessor checks
    op_wait = 1; cr_ts = 1; at_boundary(0, 0, 0, "R9 WAIT TS only");
    op_wait = 1; cr_ts = 1; cr_mp = 1; at_boundary(1, 7, 0, "R9 WAIT TS and MP");
    op_esc = 1; cr_em = 1; at_boundary(1, 7, 0, "R9 ESC EM");
    op_esc = 1; cr_ts = 1; at_boundary(1, 7, 0, "R9 ESC TS");
    op_esc = 1; fpu_error = 1; at_boundary(1, 16, 0, "R9 ESC error");
    op_wait = 1; cr_ts = 1; cr_mp = 1; fpu_error = 1; at_boundary(1, 7, 0, "R9 7 before 16");
    op_wait = 1; fpu_error = 1; at_boundary(1, 16, 0, "R9 WAIT error");
    fpu_error = 1; at_boundary(0, 0, 0, "R9 error ignored without opcode");

    // R10 operand transfer
    xfer_flt = 1; xfer_code = 2'd3; op_esc = 1; fpu_error = 1;
    at_boundary(1, 16, 0, "R3 error pin over transfer fault");
    xfer_flt = 1; xfer_code = 2'd3; at_boundary(1, 13, 0, "R10 code 3");
    pulse_done();
    illegal_op = 1; xfer_flt = 1; at_boundary(1, 6, 0, "R3 decode over transfer");

    // R11 double fault
    xfer_flt = 1; xfer_code = 2'd0; at_boundary(1, 11, 0, "R10 code 0");
    illegal_op = 1; at_boundary(1, 8, 0, "R11 escalate to 8");
    illegal_op = 1; at_boundary(1, 6, 0, "R11 cleared by dispatch");
    xfer_flt = 1; xfer_code = 2'd1; at_boundary(1, 12, 0, "R10 code 1");
    pulse_done();
    illegal_op = 1; at_boundary(1, 6, 0, "R11 cleared by invoke_done");
    xfer_flt = 1; xfer_code = 2'd2; at_boundary(1, 13, 0, "R10 code 2");
    intr_req = 1; int_enable = 1; intr_vec = 8'h21;
    at_boundary(1, 8'h21, 1, "R11 external not escalated");
    trap_step = 1; at_boundary(1, 1, 0, "R11 window closed by INTR");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule